// File: doc/BRIEF.md
# Pin-wise DC leakage screening sequencer

This block runs the electrical screen that a sensor die receives before any imaging. It steps an external analog switch matrix and current meter through three passes. The first pass is a resistance probe across neighbouring pad pairs. The second pass drives each pin in turn at a low test level and reads the current from every other pin to ground. The third pass repeats the walk at a high test level. Each reading comes from an external meter through a request/acknowledge handshake. The block compares the reading against a programmable bound for the pass it is in.

The block never applies the high level to a die that showed a fault at a lower stress. The low pass starts only after the resistance pass is clean, and the high pass starts only after the whole low pass is clean. On the first bad reading the block removes the drive and stops. It holds the driven pin, the sensed pin and the pass of the fault for software to read. An abort input brings the block back to idle and removes the drive at once.

Top module: `leak_screen_seq`

## Requirements
- R1: After reset, and whenever the block is idle, `level_o` is 0 (drive off), `meas_req_o` is low and `busy_o` is low. After reset `pass_o`, `fail_o` and `done_o` are also low.
- R2: The first pass uses level code 1. It probes pad pairs (k, k+1) for k = 0 up to N-2, with the drive on k and the sense on k+1. A reading strictly below `res_min_i` is a fault.
- R3: The current passes walk the drive pin from 0 to N-1. For each drive pin, the sense pin steps upward from 0 to N-1 and skips the drive pin. Level code 2 is the low test level and level code 3 is the high test level.
- R4: The passes always run in the order resistance, low, high. The low pass begins only after every resistance reading passed. The high pass begins only after every low reading passed.
- R5: A current reading strictly above the bound for its own pass (`lim_low_i` at level 2, `lim_high_i` at level 3) is a fault. A reading equal to its bound passes, and so does a resistance reading equal to `res_min_i`.
- R6: Each reading is requested by a one-cycle `meas_req_o` pulse. The reading is taken from `meas_val_i` in the first later cycle in which `meas_ack_i` is high. An acknowledge in the cycle of the request itself is ignored.
- R7: On the first fault, in the cycle after the acknowledge: the drive goes off, `fail_o` rises and `done_o` pulses for one cycle. `pass_o` stays low, and `fail_drive_o`, `fail_sense_o` and `fail_phase_o` hold the pins and the level code of that reading. No further request follows.
- R8: When the last high-level reading passes, in the next cycle `done_o` pulses for one cycle, `pass_o` rises and the drive goes off.
- R9: When `abort_i` is high, in the next cycle the block is idle: drive off, `pass_o` and `fail_o` low, and no `done_o` pulse.
- R10: The pin count N is sampled at start. A programmed value below 2 is treated as 2, and a value above 64 is treated as 64.
- R11: A `start_i` pulse while the block is busy has no effect on the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a screen when idle |
| abort_i | input | 1 | Stop and remove drive |
| pin_count_i | input | 7 | Number of pins N |
| res_min_i | input | 16 | Lowest acceptable resistance reading |
| lim_low_i | input | 16 | Highest acceptable current at low level |
| lim_high_i | input | 16 | Highest acceptable current at high level |
| drive_pin_o | output | 6 | Index of the driven pin |
| sense_pin_o | output | 6 | Index of the sensed pin |
| level_o | output | 2 | 0 off, 1 resistance probe, 2 low, 3 high |
| meas_req_o | output | 1 | Reading request pulse |
| meas_ack_i | input | 1 | Meter has a reading |
| meas_val_i | input | 16 | Reading from the meter |
| busy_o | output | 1 | Screen in progress |
| done_o | output | 1 | One-cycle end-of-screen pulse |
| pass_o | output | 1 | Last screen passed |
| fail_o | output | 1 | Last screen found a fault |
| fail_drive_o | output | 6 | Driven pin at the fault |
| fail_sense_o | output | 6 | Sensed pin at the fault |
| fail_phase_o | output | 2 | Level code at the fault |

## Verification
The bench builds the block with its defaults: at most 64 pins and 16-bit readings. It programs pin counts of 2, 3, 4 and 5, and also the out-of-range values 0 and 70. The 70 run walks the full 64-pin sequence of more than eight thousand readings, so the clamp and the last-pin boundary of the walk can both be reached. The bench injects faults in each of the three passes, including the final reading of the high pass. It also runs once with every reading exactly at its bound, and once each with a spurious acknowledge, a start pulse during a run and a mid-run abort.

// File: rtl/leak_pkg.sv
package leak_pkg;

    typedef enum logic [1:0] {
        LVL_OFF  = 2'd0,
        LVL_RES  = 2'd1,
        LVL_LOW  = 2'd2,
        LVL_HIGH = 2'd3
    } level_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } state_e;

    function automatic level_e next_level(input level_e cur);
        case (cur)
            LVL_RES: return LVL_LOW;
            LVL_LOW: return LVL_HIGH;
            default: return LVL_OFF;
        endcase
    endfunction

endpackage

// File: rtl/lk_pin_walker.sv
module lk_pin_walker
    import leak_pkg::*;
#(
    parameter int MAX_PINS = 64,
    parameter int PIN_W    = $clog2(MAX_PINS),
    parameter int CNT_W    = PIN_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             init_i,
    input  logic             step_i,
    input  logic             pair_i,
    input  logic [CNT_W-1:0] n_pins_i,
    output logic [PIN_W-1:0] drive_o,
    output logic [PIN_W-1:0] sense_o,
    output logic             last_o
);
    localparam int W2 = CNT_W + 1;

    logic [PIN_W-1:0] drive_q, sense_q;
    logic [W2-1:0]    d_x, s_x, n_x, s1, sp;

    always_comb begin
        d_x = W2'(drive_q);
        s_x = W2'(sense_q);
        n_x = W2'(n_pins_i);
        s1  = s_x + W2'(1);
        sp  = (s1 == d_x) ? s1 + W2'(1) : s1;
        if (pair_i)
            last_o = (s1 == n_x);
        else
            last_o = (d_x + W2'(1) == n_x) && (sp >= n_x);
    end

    always_ff @(posedge clk) begin
        if (rst || init_i) begin
            drive_q <= '0;
            sense_q <= PIN_W'(1);
        end else if (step_i) begin
            if (pair_i) begin
                drive_q <= PIN_W'(d_x + W2'(1));
                sense_q <= PIN_W'(s1);
            end else if (sp < n_x) begin
                sense_q <= PIN_W'(sp);
            end else begin
                drive_q <= PIN_W'(d_x + W2'(1));
                sense_q <= '0;
            end
        end
    end

    assign drive_o = drive_q;
    assign sense_o = sense_q;

endmodule

// File: rtl/lk_limit_judge.sv
module lk_limit_judge
    import leak_pkg::*;
#(
    parameter int VAL_W = 16
) (
    input  level_e           phase_i,
    input  logic [VAL_W-1:0] value_i,
    input  logic [VAL_W-1:0] res_min_i,
    input  logic [VAL_W-1:0] lim_low_i,
    input  logic [VAL_W-1:0] lim_high_i,
    output logic             bad_o
);
    always_comb begin
        case (phase_i)
            LVL_RES:  bad_o = (value_i < res_min_i);
            LVL_LOW:  bad_o = (value_i > lim_low_i);
            LVL_HIGH: bad_o = (value_i > lim_high_i);
            default:  bad_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/leak_screen_seq.sv
module leak_screen_seq
    import leak_pkg::*;
#(
    parameter int MAX_PINS = 64,
    parameter int VAL_W    = 16,
    parameter int PIN_W    = $clog2(MAX_PINS),
    parameter int CNT_W    = PIN_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             abort_i,
    input  logic [CNT_W-1:0] pin_count_i,
    input  logic [VAL_W-1:0] res_min_i,
    input  logic [VAL_W-1:0] lim_low_i,
    input  logic [VAL_W-1:0] lim_high_i,
    output logic [PIN_W-1:0] drive_pin_o,
    output logic [PIN_W-1:0] sense_pin_o,
    output logic [1:0]       level_o,
    output logic             meas_req_o,
    input  logic             meas_ack_i,
    input  logic [VAL_W-1:0] meas_val_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             pass_o,
    output logic             fail_o,
    output logic [PIN_W-1:0] fail_drive_o,
    output logic [PIN_W-1:0] fail_sense_o,
    output logic [1:0]       fail_phase_o
);
    localparam logic [CNT_W-1:0] N_MIN = CNT_W'(2);
    localparam logic [CNT_W-1:0] N_MAX = CNT_W'(MAX_PINS);

    state_e           state_q;
    level_e           phase_q, fphase_q;
    logic [CNT_W-1:0] cnt_q, n_eff;
    logic             done_q, pass_q, fail_q;
    logic [PIN_W-1:0] fdrive_q, fsense_q;
    logic             bad, last, take, w_init, w_step;

    always_comb begin
        if (pin_count_i < N_MIN)      n_eff = N_MIN;
        else if (pin_count_i > N_MAX) n_eff = N_MAX;
        else                          n_eff = pin_count_i;
    end

    lk_limit_judge #(.VAL_W(VAL_W)) judge_i (
        .phase_i   (phase_q),
        .value_i   (meas_val_i),
        .res_min_i (res_min_i),
        .lim_low_i (lim_low_i),
        .lim_high_i(lim_high_i),
        .bad_o     (bad)
    );

    assign take   = !abort_i && (state_q == ST_WAIT) && meas_ack_i;
    assign w_init = (!abort_i && state_q == ST_IDLE && start_i)
                  || (take && !bad && last && phase_q != LVL_HIGH);
    assign w_step = take && !bad && !last;

    lk_pin_walker #(.MAX_PINS(MAX_PINS), .PIN_W(PIN_W), .CNT_W(CNT_W)) walk_i (
        .clk     (clk),
        .rst     (rst),
        .init_i  (w_init),
        .step_i  (w_step),
        .pair_i  (phase_q == LVL_RES),
        .n_pins_i(cnt_q),
        .drive_o (drive_pin_o),
        .sense_o (sense_pin_o),
        .last_o  (last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            phase_q  <= LVL_OFF;
            fphase_q <= LVL_OFF;
            cnt_q    <= N_MIN;
            done_q   <= 1'b0;
            pass_q   <= 1'b0;
            fail_q   <= 1'b0;
            fdrive_q <= '0;
            fsense_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (abort_i) begin
                state_q <= ST_IDLE;
                phase_q <= LVL_OFF;
                pass_q  <= 1'b0;
                fail_q  <= 1'b0;
            end else begin
                case (state_q)
                    ST_IDLE: if (start_i) begin
                        state_q <= ST_REQ;
                        phase_q <= LVL_RES;
                        pass_q  <= 1'b0;
                        fail_q  <= 1'b0;
                        cnt_q   <= n_eff;
                    end
                    ST_REQ: state_q <= ST_WAIT;
                    ST_WAIT: if (meas_ack_i) begin
                        if (bad) begin
                            state_q  <= ST_IDLE;
                            phase_q  <= LVL_OFF;
                            fail_q   <= 1'b1;
                            done_q   <= 1'b1;
                            fdrive_q <= drive_pin_o;
                            fsense_q <= sense_pin_o;
                            fphase_q <= phase_q;
                        end else if (last && phase_q == LVL_HIGH) begin
                            state_q <= ST_IDLE;
                            phase_q <= LVL_OFF;
                            pass_q  <= 1'b1;
                            done_q  <= 1'b1;
                        end else begin
                            state_q <= ST_REQ;
                            if (last) phase_q <= next_level(phase_q);
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    assign busy_o       = (state_q != ST_IDLE);
    assign level_o      = busy_o ? phase_q : LVL_OFF;
    assign meas_req_o   = (state_q == ST_REQ);
    assign done_o       = done_q;
    assign pass_o       = pass_q;
    assign fail_o       = fail_q;
    assign fail_drive_o = fdrive_q;
    assign fail_sense_o = fsense_q;
    assign fail_phase_o = fphase_q;

    // R1: a request is never issued with the drive off
    assert_req_driven_R1: assert property (@(posedge clk) disable iff (rst)
        meas_req_o |-> (level_o != 2'(LVL_OFF)));

    // R3: the sensed pin is never the driven pin when a reading is requested
    assert_sense_not_drive_R3: assert property (@(posedge clk) disable iff (rst)
        meas_req_o |-> (drive_pin_o != sense_pin_o));

    // R4: the high level is entered only from the low level
    assert_high_after_low_R4: assert property (@(posedge clk) disable iff (rst)
        (level_o == 2'(LVL_HIGH) && $past(level_o) != 2'(LVL_HIGH))
        |-> ($past(level_o) == 2'(LVL_LOW)));

    // R4: the low level is entered only from the resistance probe
    assert_low_after_res_R4: assert property (@(posedge clk) disable iff (rst)
        (level_o == 2'(LVL_LOW) && $past(level_o) != 2'(LVL_LOW))
        |-> ($past(level_o) == 2'(LVL_RES)));

    // R6: a request lasts a single cycle
    assert_req_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        meas_req_o |=> !meas_req_o);

    // R7: a raised fail keeps the drive off
    assert_fail_off_R7: assert property (@(posedge clk) disable iff (rst)
        (fail_o && !busy_o) |-> (level_o == 2'(LVL_OFF)));

    // R8: done is a one-cycle pulse and the verdicts exclude each other
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    assert_verdict_excl_R8: assert property (@(posedge clk) disable iff (rst)
        !(pass_o && fail_o));

    // R9: abort leaves the block idle with drive off in the next cycle
    assert_abort_idle_R9: assert property (@(posedge clk) disable iff (rst)
        abort_i |=> (!busy_o && level_o == 2'(LVL_OFF) && !done_o));

endmodule

// File: tb/leak_screen_seq_tb_top.sv
module leak_screen_seq_tb_top;

    localparam int RES_MIN = 500;
    localparam int LIM_LO  = 100;
    localparam int LIM_HI  = 300;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0, abort_i = 1'b0, meas_ack_i = 1'b0;
    logic [6:0]  pin_count_i = 7'd4;
    logic [15:0] res_min_i = 16'(RES_MIN), lim_low_i = 16'(LIM_LO), lim_high_i = 16'(LIM_HI);
    logic [15:0] meas_val_i = '0;
    logic [5:0]  drive_pin_o, sense_pin_o, fail_drive_o, fail_sense_o;
    logic [1:0]  level_o, fail_phase_o;
    logic        meas_req_o, busy_o, done_o, pass_o, fail_o;

    int tests = 0, fails = 0;

    always #4 clk = ~clk;

    leak_screen_seq dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .abort_i(abort_i),
        .pin_count_i(pin_count_i), .res_min_i(res_min_i), .lim_low_i(lim_low_i),
        .lim_high_i(lim_high_i), .drive_pin_o(drive_pin_o), .sense_pin_o(sense_pin_o),
        .level_o(level_o), .meas_req_o(meas_req_o), .meas_ack_i(meas_ack_i),
        .meas_val_i(meas_val_i), .busy_o(busy_o), .done_o(done_o), .pass_o(pass_o),
        .fail_o(fail_o), .fail_drive_o(fail_drive_o), .fail_sense_o(fail_sense_o),
        .fail_phase_o(fail_phase_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // R1: compared on every clock once out of reset: idle means drive off, no request
    always @(negedge clk) begin
        if (!rst && !busy_o) begin
            check(level_o == 2'd0, "R1 idle level", int'(level_o), 0);
            check(meas_req_o == 1'b0, "R1 idle request", int'(meas_req_o), 0);
        end
    end

    // Behavioural model: expected readings as queues, verdict from the fault index
    task automatic run(input int n_prog, input int bad_idx, input int dly,
                       input bit at_bound, input int start_at, input int abort_at,
                       input bit spurious);
        int q_l[$], q_d[$], q_s[$];
        int n, idx, len, exp_reqs, val;
        bit finished;
        n = (n_prog < 2) ? 2 : ((n_prog > 64) ? 64 : n_prog);
        for (int k = 0; k < n - 1; k++) begin
            q_l.push_back(1); q_d.push_back(k); q_s.push_back(k + 1);
        end
        for (int lv = 2; lv <= 3; lv++)
            for (int d = 0; d < n; d++)
                for (int s = 0; s < n; s++)
                    if (s != d) begin
                        q_l.push_back(lv); q_d.push_back(d); q_s.push_back(s);
                    end
        len = q_l.size();
        exp_reqs = (bad_idx >= 0) ? bad_idx + 1 : len;

        @(negedge clk);
        pin_count_i = 7'(n_prog);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        idx = 0;
        finished = 1'b0;
        while (!finished) begin
            check(meas_req_o == 1'b1, "R6 request pulse high", int'(meas_req_o), 1);
            if (idx < len) begin
                check(int'(level_o) == q_l[idx], "R4 level order", int'(level_o), q_l[idx]);
                check(int'(drive_pin_o) == q_d[idx], q_l[idx] == 1 ? "R2 drive pin" : "R3 drive pin",
                      int'(drive_pin_o), q_d[idx]);
                check(int'(sense_pin_o) == q_s[idx], q_l[idx] == 1 ? "R2 sense pin" : "R3 sense pin",
                      int'(sense_pin_o), q_s[idx]);
            end
            if (spurious && idx == 0) begin
                meas_ack_i = 1'b1;
                meas_val_i = 16'd0;
            end
            @(negedge clk);
            meas_ack_i = 1'b0;
            check(meas_req_o == 1'b0, "R6 request one cycle", int'(meas_req_o), 0);
            if (spurious && idx == 0)
                check(busy_o == 1'b1 && fail_o == 1'b0, "R6 early ack ignored", int'(fail_o), 0);
            if (idx == abort_at) begin
                abort_i = 1'b1;
                @(negedge clk);
                abort_i = 1'b0;
                check(busy_o == 1'b0, "R9 abort idle", int'(busy_o), 0);
                check(level_o == 2'd0, "R9 abort drive off", int'(level_o), 0);
                check(done_o == 1'b0, "R9 no done", int'(done_o), 0);
                check(pass_o == 1'b0 && fail_o == 1'b0, "R9 verdict cleared", int'(fail_o), 0);
                repeat (3) @(negedge clk);
                check(meas_req_o == 1'b0, "R9 no further request", int'(meas_req_o), 0);
                return;
            end
            repeat (dly) @(negedge clk);
            if (idx < len) begin
                if (q_l[idx] == 1)      val = at_bound ? RES_MIN : 900;
                else if (q_l[idx] == 2) val = at_bound ? LIM_LO : 40;
                else                    val = at_bound ? LIM_HI : 250;
                if (idx == bad_idx)
                    val = (q_l[idx] == 1) ? RES_MIN - 1 : ((q_l[idx] == 2) ? LIM_LO + 1 : LIM_HI + 1);
            end else val = 0;
            meas_ack_i = 1'b1;
            meas_val_i = 16'(val);
            if (idx == start_at) start_i = 1'b1;
            @(negedge clk);
            meas_ack_i = 1'b0;
            start_i = 1'b0;
            idx++;
            if (done_o) finished = 1'b1;
            else if (idx > len || !meas_req_o) begin
                check(1'b0, "R8 sequence stalled or overran", idx, exp_reqs);
                finished = 1'b1;
            end
        end
        check(idx == exp_reqs, "R4 reading count", idx, exp_reqs);
        check(level_o == 2'd0 && busy_o == 1'b0, "R7 drive off at end", int'(level_o), 0);
        if (bad_idx >= 0) begin
            check(fail_o == 1'b1 && pass_o == 1'b0, "R7 fail verdict", int'(fail_o), 1);
            check(int'(fail_drive_o) == q_d[bad_idx], "R7 fail drive", int'(fail_drive_o), q_d[bad_idx]);
            check(int'(fail_sense_o) == q_s[bad_idx], "R7 fail sense", int'(fail_sense_o), q_s[bad_idx]);
            check(int'(fail_phase_o) == q_l[bad_idx], "R7 fail phase", int'(fail_phase_o), q_l[bad_idx]);
        end else begin
            check(pass_o == 1'b1 && fail_o == 1'b0, at_bound ? "R5 bound values pass" : "R8 pass verdict",
                  int'(pass_o), 1);
        end
        @(negedge clk);
        check(done_o == 1'b0, "R8 done single cycle", int'(done_o), 0);
        check(meas_req_o == 1'b0, "R7 no request after end", int'(meas_req_o), 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(busy_o == 1'b0 && level_o == 2'd0 && meas_req_o == 1'b0, "R1 reset idle", int'(level_o), 0);
        check(done_o == 1'b0 && pass_o == 1'b0 && fail_o == 1'b0, "R1 reset verdicts", int'(fail_o), 0);

        run(4, -1, 0, 1'b0, -1, -1, 1'b0);          // R8 clean run, fastest meter
        run(4, -1, 3, 1'b0, 5, -1, 1'b1);           // R11 start during run, R6 early ack
        run(3, 1, 1, 1'b0, -1, -1, 1'b0);           // R2 short on pair 1-2
        run(4, 3 + 7, 0, 1'b0, -1, -1, 1'b0);       // R4 low fault stops before high
        run(4, 3 + 12 + 11, 2, 1'b0, -1, -1, 1'b0); // R5 fault on last high reading
        run(5, -1, 0, 1'b1, -1, -1, 1'b0);          // R5 all readings at their bound
        run(0, -1, 0, 1'b0, -1, -1, 1'b0);          // R10 count below 2
        run(4, -1, 0, 1'b0, -1, 8, 1'b0);           // R9 abort in low pass
        run(2, -1, 1, 1'b0, -1, -1, 1'b0);          // R9 restart after abort
        run(70, -1, 0, 1'b0, -1, -1, 1'b0);         // R10 count above 64

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule